// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches up to 32 already-synchronized GPIO inputs and raises one combined interrupt line when any unmasked pin has a pending event. Each pin has its own trigger configuration, built from three control bits: a kind bit that selects edge or level, a polarity bit, and a both-edges bit. Together these select one of five modes: rising edge, falling edge, either edge, high level or low level.

Software reaches the block through a simple single-cycle register bus. The mask is never written directly. One write-only port clears mask bits and another sets them, so two agents can change different pins without a read-modify-write. Pending events are kept in a sticky status register, and a pin is cleared by writing 1 to its bit. Detection goes on while a pin is masked, so an event that occurs while masked is still recorded and shows up on the interrupt line once the pin is unmasked.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is held and right after it, the mask reads all ones, the pending status reads zero, the kind, polarity and both-edges registers read zero, and `irqOut` is low.
- R2: A write to the unmask port (address 1) clears every mask bit whose data bit is 1. Data bits that are 0 leave the matching mask bits unchanged. The mask changes only through address 1 or address 2.
- R3: A write to the set-mask port (address 2) sets every mask bit whose data bit is 1. Data bits that are 0 leave the matching mask bits unchanged. Writing all ones masks every pin.
- R4: The pending status (address 3, readable) is sticky. A bit clears only when 1 is written to it at address 3. If a trigger occurs in the same cycle as the acknowledge, the bit stays set.
- R5: A pin with kind=1, polarity=1 and both-edges=0 sets its status bit on a rising edge. An edge is the sampled input differing from its value one cycle earlier. No edge is seen in the first cycle after reset.
- R6: A pin with kind=1, polarity=0 and both-edges=0 sets its status bit on a falling edge.
- R7: A pin with kind=1 and both-edges=1 sets its status bit on either edge, whatever its polarity bit.
- R8: A pin with kind=0 sets its status bit on every cycle its input equals its polarity bit (1 means high level, 0 means low level), even right after an acknowledge. Its both-edges bit is ignored.
- R9: Detection and status latching work the same way while a pin is masked.
- R10: `irqOut` equals the OR over all pins of (status AND NOT mask), delayed by one register stage.
- R11: The address map is: 0 mask (read-only), 1 unmask (write-only), 2 set-mask (write-only), 3 status, 4 kind, 5 polarity, 6 both-edges. Kind, polarity and both-edges read back what was written. Addresses 1, 2 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 3 | Register address for both reads and writes |
| regWdata | input | NUM_PINS | Write data, one bit per pin |
| regRdata | output | NUM_PINS | Combinational read data for `regAddr` |
| pinIn | input | NUM_PINS | Synchronized pin levels |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
The assertions check, on every cycle, that the mask moves only in the direction a port allows, that it stays unchanged unless address 1 or 2 is written, that status bits never drop without an acknowledge, and that the interrupt line follows the unmasked pending set one cycle later. Which pins set a status bit in each cycle depends on the mode decode. The bench shows this with a reference model run over every combination of kind, polarity and both-edges against full sweeps of input patterns, with acknowledges and mask changes mixed in. Directed scenarios cover the rest: the reset values, ignored zero bits, read-back of the address map, and events latched while masked.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MASK     = 3'd0,
    REG_UNMASK   = 3'd1,
    REG_SETMASK  = 3'd2,
    REG_PEND     = 3'd3,
    REG_KIND     = 3'd4,
    REG_POLARITY = 3'd5,
    REG_BOTHEDGE = 3'd6
  } regSel_e;

  // one-cycle strobes from bus decode to the datapath
  typedef struct packed {
    logic unmaskWr;
    logic maskWr;
    logic ackWr;
    logic kindWr;
    logic polWr;
    logic bothWr;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] maskQ,
  input  logic [NUM_PINS-1:0] statusQ,
  input  logic [NUM_PINS-1:0] kindQ,
  input  logic [NUM_PINS-1:0] polQ,
  input  logic [NUM_PINS-1:0] bothQ,
  output ctrlStrobe_t         strobes,
  output logic [NUM_PINS-1:0] regRdata
);

  always_comb begin
    strobes          = '0;
    strobes.unmaskWr = regWr && (regAddr == REG_UNMASK);
    strobes.maskWr   = regWr && (regAddr == REG_SETMASK);
    strobes.ackWr    = regWr && (regAddr == REG_PEND);
    strobes.kindWr   = regWr && (regAddr == REG_KIND);
    strobes.polWr    = regWr && (regAddr == REG_POLARITY);
    strobes.bothWr   = regWr && (regAddr == REG_BOTHEDGE);
  end

  always_comb begin
    case (regAddr)
      REG_MASK:     regRdata = maskQ;
      REG_PEND:     regRdata = statusQ;
      REG_KIND:     regRdata = kindQ;
      REG_POLARITY: regRdata = polQ;
      REG_BOTHEDGE: regRdata = bothQ;
      default:      regRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobes,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] maskQ,
  output logic [NUM_PINS-1:0] statusQ,
  output logic [NUM_PINS-1:0] kindQ,
  output logic [NUM_PINS-1:0] polQ,
  output logic [NUM_PINS-1:0] bothQ,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] prevQ;
  logic                primedQ;
  logic [NUM_PINS-1:0] riseEv, fallEv, hitVec, ackVec;

  assign riseEv = pinIn & ~prevQ & {NUM_PINS{primedQ}};
  assign fallEv = ~pinIn & prevQ & {NUM_PINS{primedQ}};
  assign ackVec = strobes.ackWr ? wdata : '0;

  // per-pin trigger mode select
  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    always_comb begin
      if (!kindQ[gi])
        hitVec[gi] = polQ[gi] ? pinIn[gi] : ~pinIn[gi];
      else if (bothQ[gi])
        hitVec[gi] = riseEv[gi] | fallEv[gi];
      else
        hitVec[gi] = polQ[gi] ? riseEv[gi] : fallEv[gi];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= '0;
      primedQ <= 1'b0;
      maskQ   <= '1;
      statusQ <= '0;
      kindQ   <= '0;
      polQ    <= '0;
      bothQ   <= '0;
      irqOut  <= 1'b0;
    end else begin
      prevQ   <= pinIn;
      primedQ <= 1'b1;
      if (strobes.unmaskWr)
        maskQ <= maskQ & ~wdata;
      else if (strobes.maskWr)
        maskQ <= maskQ | wdata;
      statusQ <= (statusQ & ~ackVec) | hitVec;
      if (strobes.kindWr) kindQ <= wdata;
      if (strobes.polWr)  polQ  <= wdata;
      if (strobes.bothWr) bothQ <= wdata;
      irqOut  <= |(statusQ & ~maskQ);
    end
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [2:0]          regAddr,
  input  logic [NUM_PINS-1:0] regWdata,
  output logic [NUM_PINS-1:0] regRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                irqOut
);

  ctrlStrobe_t         strobes;
  logic [NUM_PINS-1:0] maskVec, statusVec, kindVec, polVec, bothVec;

  gpio_irq_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .regWr    (regWr),
    .regAddr  (regAddr),
    .maskQ    (maskVec),
    .statusQ  (statusVec),
    .kindQ    (kindVec),
    .polQ     (polVec),
    .bothQ    (bothVec),
    .strobes  (strobes),
    .regRdata (regRdata)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wdata   (regWdata),
    .pinIn   (pinIn),
    .maskQ   (maskVec),
    .statusQ (statusVec),
    .kindQ   (kindVec),
    .polQ    (polVec),
    .bothQ   (bothVec),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWr,
  input logic [2:0]          regAddr,
  input logic [NUM_PINS-1:0] regWdata,
  input logic [NUM_PINS-1:0] maskVec,
  input logic [NUM_PINS-1:0] statusVec,
  input logic                irqOut
);

  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd1) |=> ((maskVec & $past(regWdata)) == '0)); // R2

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && (regAddr == 3'd1 || regAddr == 3'd2)) |=> $stable(maskVec)); // R2

  AST_SETMASK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd2) |=> ((maskVec & $past(regWdata)) == $past(regWdata))); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == 3'd3) |=> ((statusVec & $past(statusVec)) == $past(statusVec))); // R4

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (irqOut == $past(|(statusVec & ~maskVec)))); // R10

endmodule

bind gpio_irq_unit gpio_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWr     (regWr),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .maskVec   (maskVec),
  .statusVec (statusVec),
  .irqOut    (irqOut)
);

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWr = 1'b0;
  logic [2:0]   regAddr = 3'd0;
  logic [N-1:0] regWdata = '0;
  logic [N-1:0] regRdata;
  logic [N-1:0] pinIn = '0;
  logic         irqOut;

  int checks = 0;
  int errors = 0;
  logic chkOn = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_unit #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn), .irqOut(irqOut)
  );

  // ---------------- reference model built from the requirements
  logic [N-1:0] mMask, mStat, mKind, mPol, mBoth, mPrev;
  logic         mPrimed, mIrq;
  logic [N-1:0] mHit;

  function automatic logic modeHit(input logic k, input logic p, input logic b,
                                   input logic prv, input logic cur, input logic primed);
    if (!k) return (cur == p);                             // R8
    if (b)  return primed && (cur != prv);                 // R7
    if (p)  return primed && cur && !prv;                  // R5
    return primed && !cur && prv;                          // R6
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask <= '1; mStat <= '0; mKind <= '0; mPol <= '0; mBoth <= '0;
      mPrev <= '0; mPrimed <= 1'b0; mIrq <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++)
        mHit[i] = modeHit(mKind[i], mPol[i], mBoth[i], mPrev[i], pinIn[i], mPrimed);
      mIrq    <= |(mStat & ~mMask);
      mStat   <= (mStat & ~((regWr && regAddr == 3'd3) ? regWdata : '0)) | mHit;
      if (regWr && regAddr == 3'd1) mMask <= mMask & ~regWdata;
      if (regWr && regAddr == 3'd2) mMask <= mMask | regWdata;
      if (regWr && regAddr == 3'd4) mKind <= regWdata;
      if (regWr && regAddr == 3'd5) mPol  <= regWdata;
      if (regWr && regAddr == 3'd6) mBoth <= regWdata;
      mPrev   <= pinIn;
      mPrimed <= 1'b1;
    end
  end

  function automatic logic [N-1:0] expRd(input logic [2:0] a);
    case (a)
      3'd0: return mMask;
      3'd3: return mStat;
      3'd4: return mKind;
      3'd5: return mPol;
      3'd6: return mBoth;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (rstN && chkOn) begin
      check("R10 irq", 32'(irqOut), 32'(mIrq));
      case (regAddr)
        3'd0:    check("R2/R3 mask read", 32'(regRdata), 32'(expRd(regAddr)));
        3'd3:    check("R4/R5/R6/R7/R8/R9 status read", 32'(regRdata), 32'(expRd(regAddr)));
        default: check("R11 read", 32'(regRdata), 32'(expRd(regAddr)));
      endcase
    end
  end

  task automatic writeReg(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic readChk(input string tag, input logic [2:0] a, input logic [N-1:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, 32'(regRdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: values while held in reset
    repeat (2) @(posedge clk);
    readChk("R1 mask in reset", 3'd0, '1);
    readChk("R1 status in reset", 3'd3, '0);
    readChk("R1 kind in reset", 3'd4, '0);
    readChk("R1 both in reset", 3'd6, '0);
    check("R1 irq in reset", 32'(irqOut), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    chkOn = 1'b1;
    readChk("R1 mask after reset", 3'd0, '1);

    // R11 address map
    writeReg(3'd4, 8'hA5);
    readChk("R11 kind readback", 3'd4, 8'hA5);
    writeReg(3'd5, 8'h3C);
    readChk("R11 polarity readback", 3'd5, 8'h3C);
    readChk("R11 unmask port reads zero", 3'd1, '0);
    readChk("R11 setmask port reads zero", 3'd2, '0);
    readChk("R11 unused reads zero", 3'd7, '0);
    writeReg(3'd4, 8'h00);
    writeReg(3'd5, 8'h00);

    // R2 / R3 zero bits ignored, ones act
    writeReg(3'd1, 8'h00);
    readChk("R2 zero unmask ignored", 3'd0, 8'hFF);
    writeReg(3'd1, 8'h0F);
    readChk("R2 unmask clears", 3'd0, 8'hF0);
    writeReg(3'd2, 8'h00);
    readChk("R3 zero setmask ignored", 3'd0, 8'hF0);
    writeReg(3'd2, 8'hFF);
    readChk("R3 all ones masks all", 3'd0, 8'hFF);

    // R9: pin0 rising while masked, then unmask
    writeReg(3'd4, 8'h01);
    writeReg(3'd5, 8'h01);
    writeReg(3'd3, 8'h01);
    regAddr = 3'd3;
    @(negedge clk); pinIn = 8'h01;
    @(posedge clk); #3;
    check("R9 masked edge latched", 32'(regRdata[0]), 32'd1);
    check("R9 masked irq low", 32'(irqOut), 32'd0);
    // R8: low-level pin1 re-sets right after ack
    writeReg(3'd3, 8'h02);
    readChk("R8 level re-asserts after ack", 3'd3, mStat | 8'h02);
    check("R8 level bit1 set", 32'(regRdata[1]), 32'd1);
    writeReg(3'd1, 8'h01);
    @(posedge clk); #3;
    check("R10 irq after unmask", 32'(irqOut), 32'd1);
    // R4: ack pin0 (input stays high, rising mode)
    writeReg(3'd3, 8'h01);
    readChk("R4 ack clears", 3'd3, mStat);
    check("R4 bit0 clear", 32'(regRdata[0]), 32'd0);

    // sweeps: every mode combination across pins, all input patterns
    for (int pass = 0; pass < 4; pass++) begin
      logic [N-1:0] k, p, b;
      k = (pass[0]) ? 8'h0F : 8'hF0;
      p = (pass[1]) ? 8'h33 : 8'hCC;
      b = 8'hAA ^ {8{pass[0]}};
      writeReg(3'd4, k);
      writeReg(3'd5, p);
      writeReg(3'd6, b);
      writeReg(3'd1, 8'hFF);
      writeReg(3'd3, 8'hFF);
      for (int v = 0; v < 256; v++) begin
        logic [N-1:0] pv;
        @(negedge clk);
        pv = (pass < 2) ? N'(v ^ (v >> 1)) : N'(v * 37 + pass);
        pinIn = pv;
        regWr = 1'b0;
        regWdata = '0;
        regAddr = (v % 3 == 0) ? 3'd0 : 3'd3;
        if (v % 7 == 3) begin
          regWr = 1'b1; regAddr = 3'd3; regWdata = N'(v * 11);
        end else if (v % 13 == 5) begin
          regWr = 1'b1; regAddr = 3'd2; regWdata = N'(v);
        end else if (v % 13 == 9) begin
          regWr = 1'b1; regAddr = 3'd1; regWdata = N'(v * 3);
        end
      end
      @(negedge clk);
      regWr = 1'b0;
      regAddr = 3'd3;
    end

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule